// File: doc/BRIEF.md
# Weighted P/Q Parity Engine over GF(2^8)

The engine computes the two parity streams of a dual-parity disk array in one pass. Up to `MAX_SRC` source blocks, each `BLK_BEATS` beats long with `LANES` bytes per beat, are fed in one after another. Every byte is weighted by a per-source coefficient and added into two block buffers. The P buffer uses the P coefficient vector; with its reset value of all ones, P is the plain XOR of the sources. The Q buffer uses the Q coefficient vector and multiplication in GF(2^8). The reduction polynomial is x^8 plus the low byte given on `poly_i`.

Software loads both coefficient vectors while the engine is idle. It then issues a start with the source count written as count minus one. Each beat carries the index of the source it belongs to. One cycle after the last beat of the last source, `done_o` pulses and both results stream out, one block beat per cycle.

A start with the continuation flag set leaves the previous P/Q results in place. This gives the same result as appending old P, old Q and old Q as three more sources with Q weights 0, 0, 1 and P weights 1. An earlier partial result is folded into a new pass in this way.

Top module: `pq_parity_engine`

## Requirements
- R1: Each output beat `p_data_o` equals, per byte lane, the XOR over the job's sources of cp[s] times that source's byte at the same beat position, where cp is the P coefficient vector.
- R2: Each output beat `q_data_o` equals, per byte lane, the XOR over sources of cq[s] times the source byte. The product is taken in GF(2^8) with reduction polynomial x^8 + `poly_i`.
- R3: The polynomial is captured at an accepted start. Changing `poly_i` during a job does not alter that job's results.
- R4: A pulse of `coef_we_i` while idle writes `coef_data_i` into entry `coef_idx_i` of the P vector (`coef_sel_i`=0) or the Q vector (`coef_sel_i`=1). Writes while busy are ignored.
- R5: `src_cnt_m1_i` holds the number of sources minus one. A start with that field 0 (a single source) is rejected and the engine stays idle. A lone Q source is issued instead as the same source twice with second Q coefficient 0.
- R6: While running, a beat is accepted only if `beat_src_i` equals the next expected source. Sources run from index 0 upward, and each source's beats arrive in block order. A beat with any other tag is ignored.
- R7: `done_o` is high for exactly the cycle after the final beat of the last source. `out_valid_o` is high from that cycle for `BLK_BEATS` cycles, presenting beat positions 0 upward.
- R8: A start with `cont_i`=0 clears both buffers. A start with `cont_i`=1 keeps them, so new P = old P ^ new terms and new Q = old Q ^ new terms.
- R9: A coefficient of 0 gives a zero term, and a coefficient of 1 passes the source byte unchanged.
- R10: A start while the engine is busy is ignored and the running job completes with its original source count.
- R11: After reset `busy_o`, `done_o` and `out_valid_o` are 0, P coefficients are all 1 and Q coefficients are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poly_i | input | 8 | Low byte of the GF reduction polynomial |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | 1 | Vector select: 0 P, 1 Q |
| coef_idx_i | input | $clog2(MAX_SRC) | Coefficient entry index |
| coef_data_i | input | 8 | Coefficient value |
| start_i | input | 1 | Start a job |
| cont_i | input | 1 | Continuation: keep previous results |
| src_cnt_m1_i | input | $clog2(MAX_SRC) | Source count minus one |
| beat_valid_i | input | 1 | Source beat valid |
| beat_src_i | input | $clog2(MAX_SRC) | Source index of the beat |
| beat_data_i | input | LANES*8 | Source beat data |
| busy_o | output | 1 | Job running or results streaming |
| done_o | output | 1 | One-cycle completion pulse |
| out_valid_o | output | 1 | Result beat valid |
| p_data_o | output | LANES*8 | P result beat |
| q_data_o | output | LANES*8 | Q result beat |

## Verification
The bench builds the engine with its defaults: 16 sources, 4 byte lanes and 4-beat blocks. With this size a job reaching the full 4-bit count field costs under a hundred cycles, so many random jobs fit alongside the directed cases. Four lanes per beat show any lane-slicing error in the multipliers. Several polynomials, continuation chains and mid-job disturbances (wrong tags, restarts, coefficient writes, polynomial changes) are all within reach.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_OUT} pq_state_e;
endpackage

// File: rtl/pq_gf_mul.sv
module pq_gf_mul (
  input  logic [7:0] coef_i,
  input  logic [7:0] data_i,
  input  logic [7:0] poly_i,
  output logic [7:0] prod_o
);
  // shift-and-reduce, one coefficient bit per step
  always_comb begin
    logic [7:0] a;
    logic [7:0] acc;
    a   = data_i;
    acc = '0;
    for (int i = 0; i < 8; i++) begin
      if (coef_i[i]) acc = acc ^ a;
      a = a[7] ? ({a[6:0], 1'b0} ^ poly_i) : {a[6:0], 1'b0};
    end
    prod_o = acc;
  end

  always_comb begin
    if (coef_i == 8'd0) assert_zero_coef_R9: assert (prod_o == 8'd0);
    if (coef_i == 8'd1) assert_unit_coef_R9: assert (prod_o == data_i);
  end
endmodule

// File: rtl/pq_coef_bank.sv
module pq_coef_bank #(
  parameter int NSRC = 16,
  parameter int IW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    cp_o,
  output logic [7:0]    cq_o
);
  logic [7:0] cp_q [NSRC];
  logic [7:0] cq_q [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cp_q[g] <= 8'd1;
        cq_q[g] <= 8'd0;
      end else if (we_i && idx_i == IW'(g)) begin
        if (sel_i) cq_q[g] <= data_i;
        else       cp_q[g] <= data_i;
      end
    end
  end

  assign cp_o = cp_q[rd_idx_i];
  assign cq_o = cq_q[rd_idx_i];
endmodule

// File: rtl/pq_accum_buf.sv
module pq_accum_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  parameter int AW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          acc_i,
  input  logic [AW-1:0] acc_idx_i,
  input  logic [W-1:0]  p_term_i,
  input  logic [W-1:0]  q_term_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [W-1:0]  p_o,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] p_mem [DEPTH];
  logic [W-1:0] q_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_mem[g] <= '0;
        q_mem[g] <= '0;
      end else if (clr_i) begin
        p_mem[g] <= '0;
        q_mem[g] <= '0;
      end else if (acc_i && acc_idx_i == AW'(g)) begin
        p_mem[g] <= p_mem[g] ^ p_term_i;
        q_mem[g] <= q_mem[g] ^ q_term_i;
      end
    end
  end

  assign p_o = p_mem[rd_idx_i];
  assign q_o = q_mem[rd_idx_i];

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (p_o == '0 && q_o == '0));
endmodule

// File: rtl/pq_parity_engine.sv
module pq_parity_engine
  import pq_pkg::*;
#(
  parameter int MAX_SRC   = 16,
  parameter int LANES     = 4,
  parameter int BLK_BEATS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 poly_i,
  input  logic                       coef_we_i,
  input  logic                       coef_sel_i,
  input  logic [$clog2(MAX_SRC)-1:0] coef_idx_i,
  input  logic [7:0]                 coef_data_i,
  input  logic                       start_i,
  input  logic                       cont_i,
  input  logic [$clog2(MAX_SRC)-1:0] src_cnt_m1_i,
  input  logic                       beat_valid_i,
  input  logic [$clog2(MAX_SRC)-1:0] beat_src_i,
  input  logic [LANES*8-1:0]         beat_data_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       out_valid_o,
  output logic [LANES*8-1:0]         p_data_o,
  output logic [LANES*8-1:0]         q_data_o
);
  localparam int SW = $clog2(MAX_SRC);
  localparam int BW = (BLK_BEATS > 1) ? $clog2(BLK_BEATS) : 1;
  localparam int DW = LANES * 8;

  pq_state_e      state_q;
  logic [SW-1:0]  cnt_m1_q, cur_src_q;
  logic [BW-1:0]  beat_ptr_q, out_ptr_q;
  logic [7:0]     poly_q;
  logic           done_q;
  logic [7:0]     cp, cq;
  logic [DW-1:0]  p_term, q_term;
  logic           start_ok, beat_ok, last_beat, final_beat;

  assign start_ok   = start_i && state_q == ST_IDLE && src_cnt_m1_i != '0;
  assign beat_ok    = state_q == ST_RUN && beat_valid_i && beat_src_i == cur_src_q;
  assign last_beat  = beat_ptr_q == BW'(BLK_BEATS - 1);
  assign final_beat = beat_ok && last_beat && cur_src_q == cnt_m1_q;

  pq_coef_bank #(.NSRC(MAX_SRC), .IW(SW)) u_coef (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (coef_we_i && state_q == ST_IDLE),
    .sel_i    (coef_sel_i),
    .idx_i    (coef_idx_i),
    .data_i   (coef_data_i),
    .rd_idx_i (cur_src_q),
    .cp_o     (cp),
    .cq_o     (cq)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pq_gf_mul u_mul_p (
      .coef_i (cp), .data_i (beat_data_i[l*8 +: 8]), .poly_i (poly_q),
      .prod_o (p_term[l*8 +: 8])
    );
    pq_gf_mul u_mul_q (
      .coef_i (cq), .data_i (beat_data_i[l*8 +: 8]), .poly_i (poly_q),
      .prod_o (q_term[l*8 +: 8])
    );
  end

  pq_accum_buf #(.DEPTH(BLK_BEATS), .W(DW), .AW(BW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok && !cont_i),
    .acc_i     (beat_ok),
    .acc_idx_i (beat_ptr_q),
    .p_term_i  (p_term),
    .q_term_i  (q_term),
    .rd_idx_i  (out_ptr_q),
    .p_o       (p_data_o),
    .q_o       (q_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_m1_q   <= '0;
      cur_src_q  <= '0;
      beat_ptr_q <= '0;
      out_ptr_q  <= '0;
      poly_q     <= 8'h1D;
      done_q     <= 1'b0;
    end else begin
      done_q <= final_beat;
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q    <= ST_RUN;
          cnt_m1_q   <= src_cnt_m1_i;
          cur_src_q  <= '0;
          beat_ptr_q <= '0;
          poly_q     <= poly_i;
        end
        ST_RUN: if (beat_ok) begin
          if (last_beat) begin
            beat_ptr_q <= '0;
            if (cur_src_q == cnt_m1_q) begin
              state_q   <= ST_OUT;
              out_ptr_q <= '0;
            end else begin
              cur_src_q <= cur_src_q + SW'(1);
            end
          end else begin
            beat_ptr_q <= beat_ptr_q + BW'(1);
          end
        end
        ST_OUT: begin
          if (out_ptr_q == BW'(BLK_BEATS - 1)) state_q <= ST_IDLE;
          out_ptr_q <= out_ptr_q + BW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;
  assign out_valid_o = state_q == ST_OUT;

  assert_done_streams_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_valid_o && out_ptr_q == '0));
  assert_done_after_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(beat_valid_i && busy_o));
  assert_stream_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_ptr_q) == BW'(BLK_BEATS - 1));
  assert_short_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && src_cnt_m1_i == '0) |=> !busy_o);
  assert_restart_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cnt_m1_q));
  assert_poly_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(poly_q));
endmodule

// File: tb/tb_pq_parity_engine.sv
module tb_pq_parity_engine;
  localparam int NS = 16;
  localparam int LN = 4;
  localparam int BB = 4;
  localparam int SW = $clog2(NS);
  localparam int DW = LN * 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    poly_i = 8'h1D;
  logic          coef_we_i = 1'b0, coef_sel_i = 1'b0;
  logic [SW-1:0] coef_idx_i = '0;
  logic [7:0]    coef_data_i = '0;
  logic          start_i = 1'b0, cont_i = 1'b0;
  logic [SW-1:0] src_cnt_m1_i = '0;
  logic          beat_valid_i = 1'b0;
  logic [SW-1:0] beat_src_i = '0;
  logic [DW-1:0] beat_data_i = '0;
  logic          busy_o, done_o, out_valid_o;
  logic [DW-1:0] p_data_o, q_data_o;

  pq_parity_engine #(.MAX_SRC(NS), .LANES(LN), .BLK_BEATS(BB)) dut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  logic [7:0]    cp_m [NS];
  logic [7:0]    cq_m [NS];
  logic [DW-1:0] src_m [NS][BB];
  logic [DW-1:0] exp_p [BB];
  logic [DW-1:0] exp_q [BB];
  logic [7:0]    job_poly;
  logic [7:0]    polys [4] = '{8'h1D, 8'h2B, 8'h4D, 8'h87};

  // carry-less product then reduction by the full 9-bit polynomial
  function automatic logic [7:0] gfm(input logic [7:0] c, input logic [7:0] x, input logic [7:0] pl);
    logic [14:0] prod = '0;
    for (int i = 0; i < 8; i++) if (c[i]) prod ^= 15'(x) << i;
    for (int b = 14; b >= 8; b--) if (prod[b]) prod ^= 15'({1'b1, pl}) << (b - 8);
    return prod[7:0];
  endfunction

  function automatic logic [DW-1:0] lane_mul(input logic [7:0] c, input logic [DW-1:0] w, input logic [7:0] pl);
    logic [DW-1:0] r;
    for (int l = 0; l < LN; l++) r[l*8 +: 8] = gfm(c, w[l*8 +: 8], pl);
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_coef(input logic sel, input int idx, input logic [7:0] val);
    coef_we_i = 1'b1; coef_sel_i = sel; coef_idx_i = SW'(idx); coef_data_i = val;
    @(negedge clk_i);
    coef_we_i = 1'b0;
    if (sel) cq_m[idx] = val; else cp_m[idx] = val;
  endtask

  task automatic fill_src(input int n);
    for (int s = 0; s < n; s++)
      for (int b = 0; b < BB; b++) src_m[s][b] = $urandom;
  endtask

  // disturb: bit0 wrong tag, bit1 restart, bit2 coef write, bit3 poly change
  task automatic run_job(input int n, input logic cont, input int disturb);
    logic [7:0] save_poly = poly_i;
    job_poly = poly_i;
    if (!cont) for (int b = 0; b < BB; b++) begin exp_p[b] = '0; exp_q[b] = '0; end
    start_i = 1'b1; cont_i = cont; src_cnt_m1_i = SW'(n - 1);
    @(negedge clk_i);
    start_i = 1'b0; cont_i = 1'b0;
    for (int s = 0; s < n; s++) begin
      if (s == 1) begin
        if (disturb[0]) begin  // R6
          beat_valid_i = 1'b1; beat_src_i = '0; beat_data_i = $urandom | 32'h1;
          @(negedge clk_i); beat_valid_i = 1'b0;
        end
        if (disturb[1]) begin  // R10
          start_i = 1'b1; src_cnt_m1_i = 1; @(negedge clk_i); start_i = 1'b0;
          check("R10 busy after restart", DW'(busy_o), DW'(1));
        end
        if (disturb[2]) begin  // R4: write while busy, model unchanged
          coef_we_i = 1'b1; coef_sel_i = 1'b1; coef_idx_i = 1; coef_data_i = cq_m[1] ^ 8'h5A;
          @(negedge clk_i); coef_we_i = 1'b0;
        end
        if (disturb[3]) poly_i = job_poly ^ 8'h22;  // R3
      end
      for (int b = 0; b < BB; b++) begin
        beat_valid_i = 1'b1; beat_src_i = SW'(s); beat_data_i = src_m[s][b];
        @(negedge clk_i);
        exp_p[b] ^= lane_mul(cp_m[s], src_m[s][b], job_poly);
        exp_q[b] ^= lane_mul(cq_m[s], src_m[s][b], job_poly);
      end
      beat_valid_i = 1'b0;
    end
    check("R7 done after final beat", DW'(done_o), DW'(1));
    for (int b = 0; b < BB; b++) begin
      check("R7 out_valid", DW'(out_valid_o), DW'(1));
      check("R1 P beat", p_data_o, exp_p[b]);
      check("R2 Q beat", q_data_o, exp_q[b]);
      @(negedge clk_i);
      if (b == 0) check("R7 done one cycle", DW'(done_o), DW'(0));
    end
    check("R7 stream ends", DW'({busy_o, out_valid_o}), DW'(0));
    poly_i = save_poly;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) begin cp_m[i] = 8'd1; cq_m[i] = 8'd0; end
    repeat (3) @(negedge clk_i);
    check("R11 reset outputs", DW'({busy_o, done_o, out_valid_o}), DW'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11: reset coefficients give plain XOR for P and zero Q
    fill_src(3); run_job(3, 1'b0, 0);

    // R9 / R5: lone source for Q issued as same source twice, second weight 0
    fill_src(1);
    for (int b = 0; b < BB; b++) src_m[1][b] = src_m[0][b];
    load_coef(1'b1, 0, 8'd1); load_coef(1'b1, 1, 8'd0);
    run_job(2, 1'b0, 0);
    load_coef(1'b1, 0, 8'h37); run_job(2, 1'b0, 0);

    // R5: count field 0 rejected
    start_i = 1'b1; src_cnt_m1_i = '0; @(negedge clk_i); start_i = 1'b0;
    check("R5 single-source start rejected", DW'(busy_o), DW'(0));

    // R4: write P vector entries, check they are used
    for (int s = 0; s < NS; s++) begin load_coef(1'b0, s, 8'($urandom)); load_coef(1'b1, s, 8'($urandom)); end
    fill_src(NS); run_job(NS, 1'b0, 0);

    // R6, R10, R4 busy write, R3 poly change
    fill_src(5); run_job(5, 1'b0, 1);
    fill_src(5); run_job(5, 1'b0, 2);
    fill_src(5); run_job(5, 1'b0, 4);
    poly_i = 8'h2B; fill_src(4); run_job(4, 1'b0, 8);
    fill_src(6); run_job(6, 1'b0, 15);

    // R8: continuation keeps previous results, then a plain start clears
    fill_src(3); run_job(3, 1'b0, 0);
    fill_src(4); run_job(4, 1'b1, 0);
    fill_src(2); run_job(2, 1'b1, 0);
    fill_src(2); run_job(2, 1'b0, 0);

    // random jobs
    for (int j = 0; j < 24; j++) begin
      int n = 2 + int'($urandom_range(0, NS - 2));
      poly_i = polys[$urandom_range(0, 3)];
      for (int s = 0; s < n; s++) begin
        if ($urandom_range(0, 2) == 0) load_coef(1'b0, s, 8'($urandom));
        if ($urandom_range(0, 1) == 0) load_coef(1'b1, s, 8'($urandom));
      end
      fill_src(n);
      run_job(n, ($urandom_range(0, 4) == 0), int'($urandom_range(0, 15)) & ((n > 1) ? 15 : 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule